// File: doc/BRIEF.md
# Card Bus Clock Divider with Double-Rate Modes

This block derives the clock driven to a memory card from the host's source clock. A two-bit scheme selector picks one of four schemes. Scheme 0 is a plain integer divider. Scheme 1 forwards the source clock unchanged. Scheme 2 is a double-rate divider. Scheme 3 is the fastest double-rate scheme, and it can switch to a divide-by-two path. An eight-bit divide field and a half-rate select bit complete the setting. A one-cycle write strobe loads all three fields at once.

The output never shows a runt pulse. A new setting is taken over only while the card clock is low, so a high phase in progress always runs to its end. Every write pulls the lock flag low. The flag stays low until the divider has restarted and finished one complete output period at the new rate. The rest of the controller polls this flag before it uses the clock.

Top module: `card_clk_divider`

## Requirements
- R1: While reset is asserted, cardClk and clkLocked are low. After release the block runs scheme 0 with a divide field of 0. clkLocked is first seen high at the 4th falling source edge after the falling edge at which reset was released.
- R2: Scheme 0 (clkScheme = 0) gives a card clock period of 4*D source cycles, where D is the divide field. A field of 0 behaves as 1.
- R3: Scheme 1 (clkScheme = 1) forwards the source clock to cardClk. The divide field and halfRate have no effect.
- R4: Scheme 2 (clkScheme = 2) gives a period of 4 source cycles when the field is 0. For a nonzero field D the period is 8*D source cycles.
- R5: Scheme 3 (clkScheme = 3) with halfRate = 1 gives a period of 2 source cycles, whatever the divide field holds. With halfRate = 0, scheme 3 divides exactly as scheme 2 does.
- R6: halfRate has no effect in schemes 0, 1 and 2.
- R7: A write pulls clkLocked low by the next falling source edge. clkLocked does not rise until at least 2+2H falling edges after the write edge, where H is the new half period in source cycles (H = 1 for scheme 1).
- R8: A write that arrives while cardClk is high does not shorten that high phase. The new setting starts only from a low phase.
- R9: In all divided schemes the high and low phases are each exactly half of the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | One-cycle strobe that loads the three fields below |
| clkScheme | input | 2 | Clock scheme select (0 to 3) |
| divField | input | 8 | Divide field |
| halfRate | input | 1 | Divide-by-two override, honoured in scheme 3 only |
| cardClk | output | 1 | Clock driven to the card |
| clkLocked | output | 1 | High once the current setting has produced one full period |

## Verification
The hardest case to reach from the ports is a reconfiguration that lands in the middle of a high phase. The old phase must then finish at full length, and the new divider must start from a stretched low phase. The stimulus first locks a long half period. It then watches cardClk at falling edges and issues the write on the first sample that shows the output high. It then counts the rest of that high phase and the next full period. Each table vector also measures the time from its write to lock against the lower bound that the new period imposes.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;

  typedef enum logic [1:0] {
    SCH_DIVONLY  = 2'd0,
    SCH_BYPASS   = 2'd1,
    SCH_DDR      = 2'd2,
    SCH_DDR_FAST = 2'd3
  } clk_scheme_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // restart the divider with a new half period
    logic bypass;  // forward the source clock after this load
  } ctrl_strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic outLow;      // divided output currently low
    logic periodDone;  // this edge ends a high phase
  } dp_status_t;

endpackage

// File: rtl/card_clk_ctrl.sv
module card_clk_ctrl
  import card_clk_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = DIV_W + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [1:0]       clkScheme,
  input  logic [DIV_W-1:0] divField,
  input  logic             halfRate,
  input  dp_status_t       dpStat,
  output ctrl_strobe_t     strb,
  output logic [CNT_W-1:0] halfVal,
  output logic             clkLocked
);

  typedef enum logic [1:0] {ST_LOCKED, ST_WAIT_LOW, ST_SETTLE} ctl_state_e;

  ctl_state_e       state;
  clk_scheme_e      pendScheme;
  logic [DIV_W-1:0] pendDiv;
  logic             pendHalf;

  function automatic logic [CNT_W-1:0] calcHalf(
    input clk_scheme_e sch,
    input logic [DIV_W-1:0] dv,
    input logic hr
  );
    logic [CNT_W-1:0] ddrHalf;
    logic [CNT_W-1:0] effDiv;
    effDiv  = (dv == '0) ? CNT_W'(1) : CNT_W'(dv);
    ddrHalf = (dv == '0) ? CNT_W'(2) : (CNT_W'(dv) << 2);
    case (sch)
      SCH_DIVONLY:  calcHalf = effDiv << 1;
      SCH_BYPASS:   calcHalf = CNT_W'(1);
      SCH_DDR:      calcHalf = ddrHalf;
      default:      calcHalf = hr ? CNT_W'(1) : ddrHalf;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_SETTLE;
      pendScheme <= SCH_DIVONLY;
      pendDiv    <= '0;
      pendHalf   <= 1'b0;
      clkLocked  <= 1'b0;
    end else if (cfgWe) begin
      state      <= ST_WAIT_LOW;
      pendScheme <= clk_scheme_e'(clkScheme);
      pendDiv    <= divField;
      pendHalf   <= halfRate;
      clkLocked  <= 1'b0;
    end else begin
      case (state)
        ST_WAIT_LOW: if (dpStat.outLow) state <= ST_SETTLE;
        ST_SETTLE: begin
          if (dpStat.periodDone) begin
            state     <= ST_LOCKED;
            clkLocked <= 1'b1;
          end
        end
        default: state <= ST_LOCKED;
      endcase
    end
  end

  always_comb begin
    strb.load   = (state == ST_WAIT_LOW) && dpStat.outLow;
    strb.bypass = (pendScheme == SCH_BYPASS);
    halfVal     = calcHalf(pendScheme, pendDiv, pendHalf);
  end

  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> !clkLocked);  // R7

  AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    clkLocked |-> !strb.load);  // R7

endmodule

// File: rtl/card_clk_datapath.sv
module card_clk_datapath
  import card_clk_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int RST_HALF = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_strobe_t     strb,
  input  logic [CNT_W-1:0] halfVal,
  output dp_status_t       dpStat,
  output logic             cardClk
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] halfReg;
  logic             divQ;
  logic             bypassReg;
  logic             bypSel;
  logic             phaseEnd;

  assign phaseEnd = (cnt == halfReg - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      halfReg   <= CNT_W'(RST_HALF);
      divQ      <= 1'b0;
      bypassReg <= 1'b0;
    end else if (strb.load) begin
      cnt       <= '0;
      halfReg   <= halfVal;
      divQ      <= 1'b0;
      bypassReg <= strb.bypass;
    end else if (phaseEnd) begin
      cnt  <= '0;
      divQ <= ~divQ;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // select changes only while the source clock is low and divQ is low
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) bypSel <= 1'b0;
    else       bypSel <= bypassReg;
  end

  assign cardClk = bypSel ? clk : divQ;

  always_comb begin
    dpStat.outLow     = !divQ;
    dpStat.periodDone = divQ && phaseEnd;
  end

  AST_LOAD_IN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> !divQ);  // R8

  AST_HIGH_NOT_CUT: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(divQ) && halfReg > CNT_W'(1)) |=> divQ);  // R8

  AST_HALF_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> halfVal != '0);  // R9

endmodule

// File: rtl/card_clk_divider.sv
module card_clk_divider
  import card_clk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [1:0]       clkScheme,
  input  logic [DIV_W-1:0] divField,
  input  logic             halfRate,
  output logic             cardClk,
  output logic             clkLocked
);

  localparam int CNT_W = DIV_W + 2;

  ctrl_strobe_t     strb;
  dp_status_t       dpStat;
  logic [CNT_W-1:0] halfVal;

  card_clk_ctrl #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .clkScheme (clkScheme),
    .divField  (divField),
    .halfRate  (halfRate),
    .dpStat    (dpStat),
    .strb      (strb),
    .halfVal   (halfVal),
    .clkLocked (clkLocked)
  );

  card_clk_datapath #(.CNT_W(CNT_W), .RST_HALF(2)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .halfVal (halfVal),
    .dpStat  (dpStat),
    .cardClk (cardClk)
  );

endmodule

// File: tb/sim_card_clk_divider.sv
`timescale 1ns/1ps
module sim_card_clk_divider;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0;
  logic [1:0] clkScheme = 2'd0;
  logic [7:0] divField = 8'd0;
  logic       halfRate = 1'b0;
  logic       cardClk;
  logic       clkLocked;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  card_clk_divider u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .clkScheme(clkScheme),
    .divField(divField), .halfRate(halfRate),
    .cardClk(cardClk), .clkLocked(clkLocked)
  );

  // {scheme[21:20], div[19:12], half[11], expected half period[10:0]}; 0 = bypass
  localparam int NV = 16;
  localparam logic [21:0] VEC [NV] = '{
    {2'd0, 8'd0,   1'b0, 11'd2},
    {2'd0, 8'd1,   1'b0, 11'd2},
    {2'd0, 8'd3,   1'b0, 11'd6},
    {2'd0, 8'd2,   1'b1, 11'd4},
    {2'd1, 8'd9,   1'b0, 11'd0},
    {2'd2, 8'd0,   1'b0, 11'd2},
    {2'd2, 8'd1,   1'b0, 11'd4},
    {2'd2, 8'd5,   1'b0, 11'd20},
    {2'd2, 8'd2,   1'b1, 11'd8},
    {2'd1, 8'd0,   1'b1, 11'd0},
    {2'd3, 8'd0,   1'b0, 11'd2},
    {2'd3, 8'd3,   1'b0, 11'd12},
    {2'd3, 8'd200, 1'b1, 11'd1},
    {2'd3, 8'd0,   1'b1, 11'd1},
    {2'd0, 8'd255, 1'b0, 11'd510},
    {2'd2, 8'd255, 1'b0, 11'd1020}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chkMin(input string tag, input int act, input int lo);
    checks++;
    if (act < lo) begin
      fails++;
      $display("FAIL %s: actual %0d expected at least %0d", tag, act, lo);
    end
  endtask

  function automatic string vecTag(input logic [1:0] s, input logic h);
    if (h && s != 2'd3) return "R6";
    case (s)
      2'd0:    return "R2";
      2'd1:    return "R3";
      2'd2:    return "R4";
      default: return "R5";
    endcase
  endfunction

  // write at a falling edge; returns with cfgWe low, one falling edge later
  task automatic writeCfg(input logic [1:0] s, input logic [7:0] d, input logic h);
    clkScheme = s; divField = d; halfRate = h; cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic waitLock(output int n);
    n = 1;
    while (!clkLocked && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic measure(output int hi, output int lo);
    int guard = 0;
    while (!cardClk && guard < 3000) begin @(negedge clk); guard++; end
    hi = 0;
    while (cardClk && hi < 3000) begin hi++; @(negedge clk); end
    lo = 0;
    while (!cardClk && lo < 3000) begin lo++; @(negedge clk); end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : stim
    int n, hi, lo;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 cardClk in reset", int'(cardClk), 0);
    chk("R1 clkLocked in reset", int'(clkLocked), 0);
    rstN = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk("R1 lock after reset", int'(clkLocked), (k == 4) ? 1 : 0);
    end
    measure(hi, lo);
    chk("R1 default high", hi, 2);
    chk("R1 default low", lo, 2);

    for (int v = 0; v < NV; v++) begin
      logic [1:0] s;
      logic [7:0] d;
      logic       h;
      int         eh;
      s  = VEC[v][21:20];
      d  = VEC[v][19:12];
      h  = VEC[v][11];
      eh = int'(VEC[v][10:0]);
      writeCfg(s, d, h);
      chk("R7 lock drop", int'(clkLocked), 0);
      waitLock(n);
      chkMin("R7 lock latency", n, 2 + 2 * ((eh == 0) ? 1 : eh));
      if (eh == 0) begin
        int bad = 0;
        for (int k = 0; k < 4; k++) begin
          @(posedge clk); #5;
          if (cardClk !== 1'b1) bad++;
          @(negedge clk); #5;
          if (cardClk !== 1'b0) bad++;
        end
        chk(vecTag(s, h), bad, 0);
        @(negedge clk);
      end else begin
        measure(hi, lo);
        chk(vecTag(s, h), hi, eh);
        chk("R9 low phase", lo, eh);
      end
    end

    // R8: write during a high phase of half period 6
    writeCfg(2'd0, 8'd3, 1'b0);
    waitLock(n);
    n = 0;
    while (!cardClk && n < 100) begin @(negedge clk); n++; end
    n = 1;
    clkScheme = 2'd0; divField = 8'd1; halfRate = 1'b0; cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
    chk("R7 drop mid-phase", int'(clkLocked), 0);
    while (cardClk && n < 100) begin n++; @(negedge clk); end
    chk("R8 high phase kept", n, 6);
    measure(hi, lo);
    chk("R8 new high", hi, 2);
    chk("R8 new low", lo, 2);
    chk("R8 locked after", int'(clkLocked), 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule